// File: doc/BRIEF.md
# Cycle-Count Interrupt Timer

This block is a 16-bit down-counter that raises an interrupt request after a programmed number of processor cycles. The surrounding cartridge-mapper logic decodes the bus address. It hands the block one write strobe for each counter byte, one strobe for the control register, the 8-bit write data and a one-cycle pulse for each processor cycle.

Software loads the live count one byte at a time. There is no separate reload value. Writing the control register sets or clears the run enable from data bit 0. The same write also drops any pending request, whatever value is written. While running, the count falls by one on each processor-cycle pulse. The request goes high when a decrement lands on zero. After that the count wraps to all ones and keeps falling. The request stays high until the next control write.

Top module: `cyc_irq_timer`

## Requirements
- R1: A synchronous active-high reset clears the count to 0, the enable to 0 and `irq` to 0. If the timer is then enabled without a load, it needs a full wrap (65536 ticks) before `irq` rises.
- R2: A write with `cnt_wr[0]` high puts `wdata` into bits 7:0 of the count and leaves bits 15:8 unchanged.
- R3: A write with `cnt_wr[1]` high puts `wdata` into bits 15:8 of the count and leaves bits 7:0 unchanged.
- R4: A write with `ctl_wr` high sets the enable to `wdata[0]` and clears `irq` in the next cycle for any data value. This clear wins over a terminal count that falls in the same cycle.
- R5: While enabled, the count falls by one in each cycle with `cpu_tick` high. Cycles without `cpu_tick` leave it unchanged.
- R6: `irq` goes high one clock after the tick whose decrement gives a count of 0000h. With a loaded value N (1 to FFFFh), that is the N-th tick after enabling.
- R7: The count does not stop at zero. It wraps to FFFFh and keeps falling, so `irq` fires again 65536 ticks after the previous terminal count.
- R8: `irq` is a level. It stays high through further ticks and through count-byte writes until a control write.
- R9: While disabled, the count holds its value whatever `cpu_tick` does.
- R10: In a cycle where any count-byte strobe is high, the write takes effect and the tick in that cycle causes no decrement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_tick | input | 1 | One pulse per processor cycle |
| cnt_wr | input | CNT_W/DATA_W (2) | Count byte write strobes, bit 0 = low byte |
| ctl_wr | input | 1 | Control write strobe (enable and acknowledge) |
| wdata | input | DATA_W (8) | Write data |
| irq | output | 1 | Active-high interrupt request level |

## Verification
The bench uses the default parameters: a 16-bit count loaded through two 8-bit lanes. At that width a complete wrap of the counter takes 65536 ticks, which is few enough to run in full. The bench therefore checks refiring after a terminal count and the long first period after reset cycle-exactly. It does not rely on a reduced-width stand-in.

// File: rtl/cyc_irq_pkg.sv
package cyc_irq_pkg;
  localparam int DEF_CNT_W  = 16;
  localparam int DEF_DATA_W = 8;

  function automatic int lanes_of(input int cnt_w, input int data_w);
    return cnt_w / data_w;
  endfunction
endpackage

// File: rtl/cyc_irq_ctrl.sv
module cyc_irq_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              run_q
);
  always_ff @(posedge clk) begin
    if (rst)         run_q <= 1'b0;
    else if (ctl_wr) run_q <= wdata[0];
  end
endmodule

// File: rtl/cyc_irq_counter.sv
module cyc_irq_counter #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  localparam int LANES = CNT_W / DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              cpu_tick,
  input  logic [LANES-1:0]  cnt_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              hit_zero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             any_wr;
  logic             step;
  logic [CNT_W-1:0] loaded;
  logic [CNT_W-1:0] cnt_d;

  assign any_wr = |cnt_wr;
  assign step   = run && cpu_tick && !any_wr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign loaded[g*DATA_W +: DATA_W] = cnt_wr[g] ? wdata : cnt_q[g*DATA_W +: DATA_W];
  end

  always_comb begin
    cnt_d = cnt_q;
    if (any_wr)    cnt_d = loaded;
    else if (step) cnt_d = cnt_q - ONE;
  end

  assign hit_zero = step && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cyc_irq_flag.sv
module cyc_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  input  logic hit_zero,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst)           irq_q <= 1'b0;
    else if (ack)      irq_q <= 1'b0;
    else if (hit_zero) irq_q <= 1'b1;
  end
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
  import cyc_irq_pkg::*;
#(
  parameter int CNT_W  = DEF_CNT_W,
  parameter int DATA_W = DEF_DATA_W,
  localparam int LANES = lanes_of(CNT_W, DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_tick,
  input  logic [LANES-1:0]  cnt_wr,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              irq
);
  logic             run_q;
  logic             hit_zero;
  logic [CNT_W-1:0] cnt_q;

  cyc_irq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .wdata(wdata), .run_q(run_q)
  );

  cyc_irq_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run_q), .cpu_tick(cpu_tick),
    .cnt_wr(cnt_wr), .wdata(wdata), .cnt_q(cnt_q), .hit_zero(hit_zero)
  );

  cyc_irq_flag u_flag (
    .clk(clk), .rst(rst), .ack(ctl_wr), .hit_zero(hit_zero), .irq_q(irq)
  );
endmodule

// File: rtl/cyc_irq_timer_chk.sv
module cyc_irq_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  localparam int LANES = CNT_W / DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_tick,
  input logic [LANES-1:0]  cnt_wr,
  input logic              ctl_wr,
  input logic [DATA_W-1:0] wdata,
  input logic              irq,
  input logic              run_q,
  input logic [CNT_W-1:0]  cnt_q
);
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> !irq);
  p_enable_from_bit0_r4: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> run_q == $past(wdata[0]));
  p_level_holds_r8: assert property (@(posedge clk) disable iff (rst)
    irq && !ctl_wr |=> irq);
  p_hold_disabled_r9: assert property (@(posedge clk) disable iff (rst)
    !run_q && cnt_wr == '0 |=> $stable(cnt_q));
  p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (rst)
    !cpu_tick && cnt_wr == '0 |=> $stable(cnt_q));
  p_step_down_r5: assert property (@(posedge clk) disable iff (rst)
    run_q && cpu_tick && cnt_wr == '0 |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  p_fire_at_zero_r6: assert property (@(posedge clk) disable iff (rst)
    run_q && cpu_tick && cnt_wr == '0 && !ctl_wr && cnt_q == CNT_W'(1) |=> irq);
  p_rise_only_at_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !irq && !(run_q && cpu_tick && cnt_wr == '0 && cnt_q == CNT_W'(1)) |=> !irq);
  p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
    cnt_wr[0] |=> cnt_q[DATA_W-1:0] == $past(wdata));
  p_low_lane_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_wr == LANES'(1) |=> cnt_q[CNT_W-1:DATA_W] == $past(cnt_q[CNT_W-1:DATA_W]));
  p_high_lane_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_wr == LANES'(2) |=> cnt_q[DATA_W-1:0] == $past(cnt_q[DATA_W-1:0])
                          && cnt_q[2*DATA_W-1:DATA_W] == $past(wdata));
endmodule

bind cyc_irq_timer cyc_irq_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_tick(cpu_tick), .cnt_wr(cnt_wr), .ctl_wr(ctl_wr),
  .wdata(wdata), .irq(irq), .run_q(run_q), .cnt_q(cnt_q)
);

// File: tb/test_cyc_irq_timer.sv
`timescale 1ns/1ps
module test_cyc_irq_timer;
  localparam int CLK_NS = 20;
  localparam int NVEC = 6;
  localparam logic [15:0] VECS [NVEC] = '{16'h0001, 16'h0002, 16'h00FF,
                                          16'h0100, 16'h0305, 16'h1000};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_tick = 1'b0;
  logic [1:0] cnt_wr = '0;
  logic       ctl_wr = 1'b0;
  logic [7:0] wdata = '0;
  logic       irq;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  cyc_irq_timer i_cyc_irq_timer (
    .clk(clk), .rst(rst), .cpu_tick(cpu_tick), .cnt_wr(cnt_wr),
    .ctl_wr(ctl_wr), .wdata(wdata), .irq(irq)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: irq=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic cyc(input logic t, input logic [1:0] w, input logic c, input logic [7:0] d);
    cpu_tick = t; cnt_wr = w; ctl_wr = c; wdata = d;
    @(posedge clk); #1;
    cpu_tick = 1'b0; cnt_wr = '0; ctl_wr = 1'b0; wdata = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 2'b00, 1'b0, 8'h00);
  endtask

  task automatic load(input logic [15:0] v);
    cyc(1'b0, 2'b00, 1'b1, 8'h00);
    cyc(1'b0, 2'b01, 1'b0, v[7:0]);
    cyc(1'b0, 2'b10, 1'b0, v[15:8]);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk("R1 reset irq low", irq, 1'b0);
    // R1: counter reset to 0, so enabling without load wraps first
    cyc(1'b0, 2'b00, 1'b1, 8'h01);
    ticks(5);
    chk("R1 zero after reset wraps", irq, 1'b0);
    ticks(65530);
    chk("R1 before full wrap", irq, 1'b0);
    ticks(1);
    chk("R1 fires after 65536", irq, 1'b1);

    // R2 R3 R5 R6: table of loaded values
    for (int k = 0; k < NVEC; k++) begin
      load(VECS[k]);
      cyc(1'b0, 2'b00, 1'b1, 8'h01);
      ticks(int'(VECS[k]) - 1);
      chk("R6 no fire before terminal", irq, 1'b0);
      ticks(1);
      chk("R6 fire at terminal count", irq, 1'b1);
    end

    // R2: low-byte write keeps high byte
    load(16'h0005);
    cyc(1'b0, 2'b01, 1'b0, 8'h03);
    cyc(1'b0, 2'b00, 1'b1, 8'h01);
    ticks(2); chk("R2 low-only rewrite", irq, 1'b0);
    ticks(1); chk("R2 low-only rewrite fire", irq, 1'b1);

    // R3: high-byte write keeps low byte -> 0x0102
    load(16'h0002);
    cyc(1'b0, 2'b10, 1'b0, 8'h01);
    cyc(1'b0, 2'b00, 1'b1, 8'h01);
    ticks(257); chk("R3 high-only rewrite", irq, 1'b0);
    ticks(1); chk("R3 high-only rewrite fire", irq, 1'b1);

    // R8: level holds through ticks and byte writes
    ticks(5); chk("R8 holds through ticks", irq, 1'b1);
    cyc(1'b0, 2'b01, 1'b0, 8'h44);
    cyc(1'b0, 2'b10, 1'b0, 8'h55);
    chk("R8 holds through byte writes", irq, 1'b1);
    // R4: ack with bit0 clear disables and clears
    cyc(1'b0, 2'b00, 1'b1, 8'hFE);
    chk("R4 ack clears irq", irq, 1'b0);

    // R9: disabled holds the count
    load(16'h0004);
    ticks(10);
    chk("R9 no fire while disabled", irq, 1'b0);
    cyc(1'b0, 2'b00, 1'b1, 8'h01);
    ticks(3); chk("R9 count held", irq, 1'b0);
    ticks(1); chk("R9 held count fires", irq, 1'b1);

    // R5: cycles without tick do not count
    load(16'h0003);
    cyc(1'b0, 2'b00, 1'b1, 8'h01);
    repeat (10) cyc(1'b0, 2'b00, 1'b0, 8'h00);
    ticks(2); chk("R5 idle cycles ignored", irq, 1'b0);
    ticks(1); chk("R5 fire after 3 ticks", irq, 1'b1);

    // R10: byte write beats decrement
    load(16'h0002);
    cyc(1'b0, 2'b00, 1'b1, 8'h01);
    cyc(1'b1, 2'b01, 1'b0, 8'h02);
    cyc(1'b1, 2'b10, 1'b0, 8'h00);
    ticks(1); chk("R10 write beats tick", irq, 1'b0);
    ticks(1); chk("R10 fire after 2 ticks", irq, 1'b1);

    // R4: ack wins over a same-cycle terminal count
    load(16'h0001);
    cyc(1'b0, 2'b00, 1'b1, 8'h01);
    cyc(1'b1, 2'b00, 1'b1, 8'h01);
    chk("R4 ack beats terminal", irq, 1'b0);
    ticks(3); chk("R4 no late fire", irq, 1'b0);

    // R7: wrap and refire after 65536 ticks
    load(16'h0001);
    cyc(1'b0, 2'b00, 1'b1, 8'h01);
    ticks(1); chk("R7 first fire", irq, 1'b1);
    cyc(1'b0, 2'b00, 1'b1, 8'h81);
    chk("R4 ack with odd data", irq, 1'b0);
    ticks(65535); chk("R7 no fire before wrap", irq, 1'b0);
    ticks(1); chk("R7 refire after wrap", irq, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule